// File: doc/BRIEF.md
# Partitioned Two-Group Conversion Sequencer

This block orders the work of an analog-to-digital converter between two programmed channel lists. The normal list has one slot per position, starting at slot 0. The priority list sits at the top of its slot bank. Each normal trigger converts only the next partition of the normal list, which is a short run of consecutive channels. Each priority trigger converts exactly one priority channel. Each list keeps its position between triggers, so a series of triggers walks through the whole list and then wraps back to the start.

The converter is outside the block. For each conversion the sequencer drives a channel number and a one-cycle start strobe, then waits for the converter's done pulse. Only after that pulse does it choose the next channel. A priority request that arrives while a normal partition is running is served at the next conversion boundary. The normal partition then resumes where it stopped. A one-cycle completion pulse marks the end of each list.

Top module: `adc_part_seq`

## Requirements
- R1: While reset is held low, and until the first trigger, `conv_start`, `nrm_cmpl` and `pri_cmpl` stay low. After reset, each list pointer is at its first slot.
- R2: `nrm_len` holds the normal list length minus one. The list is taken in ascending order from slots 0 to `nrm_len`. Slot k occupies `nrm_slots[k*CHW +: CHW]`.
- R3: `part_cnt` holds the partition size minus one. A normal trigger converts the next `part_cnt+1` channels of the list. The partition ends early at the last list entry, and the next trigger starts again at slot 0.
- R4: `nrm_cmpl` pulses for one cycle, the cycle after the done pulse of the last normal-list channel.
- R5: `pri_len` holds the priority list length minus one. The list uses the top slots, from `NSLOT_P-1-pri_len` up to `NSLOT_P-1`, in ascending order. Slot k occupies `pri_slots[k*CHW +: CHW]`.
- R6: Each priority trigger converts exactly one channel. `pri_cmpl` pulses for one cycle, the cycle after the done pulse of the last priority slot.
- R7: A priority trigger that arrives during a normal partition is converted after the current conversion's done pulse. The normal partition then continues from the channel it had reached.
- R8: A normal trigger is ignored while a normal partition is in progress. A priority trigger is ignored while a priority conversion is pending or running.
- R9: A change of `nrm_len` returns the normal pointer to slot 0. A change of `pri_len` returns the priority pointer to the first priority slot.
- R10: `conv_start` is a one-cycle pulse. After a start, no further start occurs until `conv_done` has been seen. `conv_is_pri` is high for priority conversions and low for normal ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nrm_len | input | $clog2(NSLOT_N) | Normal list length minus one |
| part_cnt | input | PCW | Partition size minus one |
| nrm_slots | input | NSLOT_N*CHW | Normal channel slots, slot 0 in the low bits |
| pri_len | input | $clog2(NSLOT_P) | Priority list length minus one |
| pri_slots | input | NSLOT_P*CHW | Priority channel slots, slot 0 in the low bits |
| nrm_trig | input | 1 | Normal group trigger pulse |
| pri_trig | input | 1 | Priority group trigger pulse |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | CHW | Selected channel number |
| conv_is_pri | output | 1 | Current conversion belongs to the priority group |
| nrm_cmpl | output | 1 | Normal list completed (one-cycle pulse) |
| pri_cmpl | output | 1 | Priority list completed (one-cycle pulse) |

## Verification
The hardest case to reach is a priority request that lands in the middle of a normal partition. It must arrive after the first normal start and before that conversion's done pulse. The bench enlarges the partition to three channels, raises the normal trigger, waits one cycle so that the first normal conversion is outstanding, and then pulses the priority trigger. The converter model has a fixed latency, so the bench can predict the interleaved order exactly: normal, priority, normal, normal. The ignored-trigger cases use the same timing idea. The second pulse is aimed inside a partition or conversion that is known to be running, and the bench then counts the logged conversions.

// File: rtl/adc_part_seq.sv
module adc_part_seq #(
  parameter int NSLOT_N = 16,
  parameter int NSLOT_P = 4,
  parameter int CHW     = 5,
  parameter int PCW     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NSLOT_N)-1:0] nrm_len,
  input  logic [PCW-1:0]           part_cnt,
  input  logic [NSLOT_N*CHW-1:0]   nrm_slots,
  input  logic [$clog2(NSLOT_P)-1:0] pri_len,
  input  logic [NSLOT_P*CHW-1:0]   pri_slots,
  input  logic                     nrm_trig,
  input  logic                     pri_trig,
  input  logic                     conv_done,
  output logic                     conv_start,
  output logic [CHW-1:0]           conv_chan,
  output logic                     conv_is_pri,
  output logic                     nrm_cmpl,
  output logic                     pri_cmpl
);
  localparam int NW = $clog2(NSLOT_N);
  localparam int PW = $clog2(NSLOT_P);
  localparam logic [PW-1:0] PTOP = PW'(NSLOT_P - 1);

  logic [CHW-1:0] nslot [NSLOT_N];
  logic [CHW-1:0] pslot [NSLOT_P];

  for (genvar i = 0; i < NSLOT_N; i++) begin : g_nslot
    assign nslot[i] = nrm_slots[i*CHW +: CHW];
  end
  for (genvar j = 0; j < NSLOT_P; j++) begin : g_pslot
    assign pslot[j] = pri_slots[j*CHW +: CHW];
  end

  logic [NW-1:0]  nrm_ptr, nrm_len_q;
  logic [PW-1:0]  pri_ptr, pri_len_q;
  logic [PCW-1:0] nrm_left;
  logic           nrm_act, pri_pend, busy, cur_pri;

  wire [PW-1:0] pri_idx = PTOP - pri_len + pri_ptr;
  wire go_pri  = !busy && pri_pend;
  wire go_nrm  = !busy && !pri_pend && nrm_act;
  wire fin     = busy && conv_done;
  wire nlen_ch = nrm_len != nrm_len_q;
  wire plen_ch = pri_len != pri_len_q;

  assign conv_is_pri = cur_pri;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrm_ptr    <= '0;
      pri_ptr    <= '0;
      nrm_len_q  <= '0;
      pri_len_q  <= '0;
      nrm_left   <= '0;
      nrm_act    <= 1'b0;
      pri_pend   <= 1'b0;
      busy       <= 1'b0;
      cur_pri    <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      nrm_cmpl   <= 1'b0;
      pri_cmpl   <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      nrm_cmpl   <= 1'b0;
      pri_cmpl   <= 1'b0;
      nrm_len_q  <= nrm_len;
      pri_len_q  <= pri_len;

      if (go_pri || go_nrm) begin
        busy       <= 1'b1;
        conv_start <= 1'b1;
        cur_pri    <= go_pri;
        conv_chan  <= go_pri ? pslot[pri_idx] : nslot[nrm_ptr];
        if (go_pri) pri_pend <= 1'b0;
      end

      if (fin) begin
        busy <= 1'b0;
        if (cur_pri) begin
          if (pri_ptr == pri_len) begin
            pri_cmpl <= 1'b1;
            pri_ptr  <= '0;
          end else begin
            pri_ptr <= pri_ptr + PW'(1);
          end
        end else begin
          if (nrm_ptr == nrm_len) begin
            nrm_cmpl <= 1'b1;
            nrm_ptr  <= '0;
            nrm_act  <= 1'b0;
          end else begin
            nrm_ptr <= nrm_ptr + NW'(1);
            if (nrm_left == '0) nrm_act <= 1'b0;
            else nrm_left <= nrm_left - PCW'(1);
          end
        end
      end

      if (nrm_trig && !nrm_act) begin
        nrm_act  <= 1'b1;
        nrm_left <= part_cnt;
      end
      if (pri_trig && !pri_pend && !(busy && cur_pri)) pri_pend <= 1'b1;

      if (nlen_ch) nrm_ptr <= '0;
      if (plen_ch) pri_ptr <= '0;
    end
  end

  a_r10_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r10_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_start);
  a_r4_nrm_cmpl_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_cmpl |-> ($past(conv_done) && !$past(cur_pri)));
  a_r6_pri_cmpl_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    pri_cmpl |-> ($past(conv_done) && $past(cur_pri)));
  a_r2_ptr_in_list: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_ptr <= nrm_len_q);
  a_r7_pri_before_nrm: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_pend && !busy) |=> (conv_start && conv_is_pri));
endmodule

// File: tb/adc_part_seq_tb.sv
module adc_part_seq_tb;
  localparam int NSN = 16, NSP = 4, CHW = 5, PCW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]         nrm_len = 4'd4;
  logic [PCW-1:0]     part_cnt = 3'd1;
  logic [NSN*CHW-1:0] nrm_slots;
  logic [1:0]         pri_len = 2'd2;
  logic [NSP*CHW-1:0] pri_slots;
  logic nrm_trig = 1'b0, pri_trig = 1'b0, conv_done = 1'b0;
  logic conv_start, conv_is_pri, nrm_cmpl, pri_cmpl;
  logic [CHW-1:0] conv_chan;

  adc_part_seq #(.NSLOT_N(NSN), .NSLOT_P(NSP), .CHW(CHW), .PCW(PCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .nrm_len(nrm_len), .part_cnt(part_cnt),
    .nrm_slots(nrm_slots), .pri_len(pri_len), .pri_slots(pri_slots),
    .nrm_trig(nrm_trig), .pri_trig(pri_trig), .conv_done(conv_done),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_is_pri(conv_is_pri),
    .nrm_cmpl(nrm_cmpl), .pri_cmpl(pri_cmpl));

  int checks = 0, fails = 0;
  int log_ch [256];
  bit log_pri [256];
  int log_n = 0, ncmpl = 0, pcmpl = 0, mon_err = 0, lat = 0;
  bit outst = 1'b0, prev_start = 1'b0;

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (rst_n) begin
      if (nrm_cmpl) ncmpl++;
      if (pri_cmpl) pcmpl++;
      if (conv_start && (prev_start || outst)) mon_err++;
      prev_start = conv_start;
      if (conv_start) begin
        if (log_n < 256) begin
          log_ch[log_n]  = int'(conv_chan);
          log_pri[log_n] = conv_is_pri;
        end
        log_n++;
        outst = 1'b1;
        lat = 2;
      end else if (outst) begin
        if (lat == 0) begin
          conv_done = 1'b1;
          outst = 1'b0;
        end else lat--;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic exp_conv(input int base, input int n, input int c0, input int c1,
                          input int c2, input int p0, input int p1, input int p2,
                          input string tag);
    int cs[3];
    int ps[3];
    cs = '{c0, c1, c2};
    ps = '{p0, p1, p2};
    chk(log_n - base, n, {tag, " count"});
    for (int k = 0; k < n && k < 3; k++) begin
      chk(log_ch[base+k], cs[k], {tag, " chan"});
      chk(int'(log_pri[base+k]), ps[k], {tag, " group"});
    end
  endtask

  task automatic pulse_n();
    @(negedge clk) nrm_trig = 1'b1;
    @(negedge clk) nrm_trig = 1'b0;
  endtask

  task automatic pulse_p();
    @(negedge clk) pri_trig = 1'b1;
    @(negedge clk) pri_trig = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(int'(conv_start), 0, "R1 start in reset");
    chk(int'(nrm_cmpl) + int'(pri_cmpl), 0, "R1 flags in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(log_n, 0, "R1 no start without trigger");
    chk(int'(nrm_cmpl) + int'(pri_cmpl), 0, "R1 flags after reset");
  endtask

  task automatic t_partition();
    int b;
    b = log_n; pulse_n(); settle();
    exp_conv(b, 2, 5, 0, 0, 0, 0, 0, "R2 R3 part1");
    chk(ncmpl, 0, "R4 no cmpl mid list");
    b = log_n; pulse_n(); settle();
    exp_conv(b, 2, 2, 1, 0, 0, 0, 0, "R3 part2");
    b = log_n; pulse_n(); settle();
    exp_conv(b, 1, 17, 0, 0, 0, 0, 0, "R3 short last part");
    chk(ncmpl, 1, "R4 cmpl at list end");
    b = log_n; pulse_n(); settle();
    exp_conv(b, 2, 5, 0, 0, 0, 0, 0, "R3 wrap");
    b = log_n; pulse_n(); settle();
    pulse_n(); settle();
    exp_conv(b, 3, 2, 1, 17, 0, 0, 0, "R3 finish list");
    chk(ncmpl, 2, "R4 second cmpl");
  endtask

  task automatic t_ignore_nrm();
    int b;
    b = log_n;
    pulse_n();
    repeat (2) @(negedge clk);
    pulse_n();
    settle();
    exp_conv(b, 2, 5, 0, 0, 0, 0, 0, "R8 nrm retrigger ignored");
    pulse_n(); settle(); pulse_n(); settle();
    chk(ncmpl, 3, "R4 cmpl after ignore test");
  endtask

  task automatic t_priority();
    int b;
    b = log_n;
    pulse_p();
    repeat (2) @(negedge clk);
    pulse_p();
    settle();
    exp_conv(b, 1, 4, 0, 0, 1, 0, 0, "R5 R6 R8 pri single, retrigger ignored");
    chk(pcmpl, 0, "R6 no pri cmpl early");
    b = log_n; pulse_p(); settle();
    exp_conv(b, 1, 1, 0, 0, 1, 0, 0, "R5 pri slot2");
    chk(pcmpl, 0, "R6 no pri cmpl second");
    b = log_n; pulse_p(); settle();
    exp_conv(b, 1, 3, 0, 0, 1, 0, 0, "R5 pri top slot");
    chk(pcmpl, 1, "R6 pri cmpl");
  endtask

  task automatic t_preempt();
    int b;
    part_cnt = 3'd2;
    b = log_n;
    pulse_n();
    @(negedge clk);
    pulse_p();
    settle();
    chk(log_n - b, 4, "R7 preempt count");
    chk(log_ch[b], 5, "R7 first normal");
    chk(log_ch[b+1], 4, "R7 priority next");
    chk(int'(log_pri[b+1]), 1, "R7 priority group flag");
    chk(log_ch[b+2], 0, "R7 normal resumes");
    chk(log_ch[b+3], 2, "R7 normal continues");
    chk(int'(log_pri[b+3]), 0, "R10 normal group flag");
  endtask

  task automatic t_lenchg();
    int b;
    @(negedge clk) nrm_len = 4'd3;
    repeat (3) @(negedge clk);
    b = log_n; pulse_n(); settle();
    exp_conv(b, 3, 5, 0, 2, 0, 0, 0, "R9 nrm pointer reset");
    @(negedge clk) pri_len = 2'd0;
    repeat (3) @(negedge clk);
    b = log_n; pulse_p(); settle();
    exp_conv(b, 1, 3, 0, 0, 1, 0, 0, "R9 R5 pri pointer reset, single top slot");
    chk(pcmpl, 2, "R6 one-slot list cmpl");
  endtask

  task automatic t_overlong();
    int b, c;
    @(negedge clk) begin nrm_len = 4'd1; part_cnt = 3'd7; end
    repeat (3) @(negedge clk);
    c = ncmpl;
    b = log_n; pulse_n(); settle();
    exp_conv(b, 2, 5, 0, 0, 0, 0, 0, "R3 partition stops at list end");
    chk(ncmpl - c, 1, "R4 cmpl on long partition");
    b = log_n; pulse_n(); settle();
    exp_conv(b, 2, 5, 0, 0, 0, 0, 0, "R3 restart after end");
    chk(mon_err, 0, "R10 start protocol");
  endtask

  initial begin
    for (int s = 0; s < NSN; s++) nrm_slots[s*CHW +: CHW] = 5'd31;
    nrm_slots[0 +: CHW]  = 5'd5;
    nrm_slots[5 +: CHW]  = 5'd0;
    nrm_slots[10 +: CHW] = 5'd2;
    nrm_slots[15 +: CHW] = 5'd1;
    nrm_slots[20 +: CHW] = 5'd17;
    pri_slots = {5'd3, 5'd1, 5'd4, 5'd13};
    t_reset();
    t_partition();
    t_ignore_nrm();
    t_priority();
    t_preempt();
    t_lenchg();
    t_overlong();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule